// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block holds a parameterised number of 32-bit shadow words. Together they mirror a one-time-programmable fuse array, so software reads fuse contents through a fast register file and never touches the slow array. Each word sits in the bus address space at byte offset 0x400 plus sixteen times its index. A status word at offset 0x000 shows the busy, error and reload flags. Two aliases change those flags: writes to 0x004 set flags and writes to 0x008 clear them.

A reload sequencer copies the whole fuse array into the shadows. It copies one word every `relax_cycles + 1` clocks, in ascending index order. It runs once on its own when reset is released, and again each time software requests it through the set alias. Each word has two lock inputs, one for reads and one for writes. A bus access that breaks a lock, or a shadow write issued during a reload, raises a sticky error flag. Until software clears that flag through the clear alias, the bank refuses new shadow reads, shadow writes and reload requests.

The sequencer has three states. IDLE waits for a request, and moves to ARM when a request arrives. ARM loads the pacing counter and resets the word index, then moves to PACE. PACE counts the pacing counter down to zero. At zero it copies one word. After that copy it either reloads the counter and steps to the next word, or returns to IDLE once the last word is done. Reset releases the sequencer into ARM.

Top module: `fuse_shadow_bank`

## Requirements
- R1: Shadow word i is read at byte address 0x400 + 16·i, for i below NWORDS. Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is sampled. Addresses that are unaligned, out of range or unmapped read as zero, and writes to them have no effect. `bus_rdata` is zero during reset.
- R2: A read of address 0x000, 0x004 or 0x008 returns the status word: bit 8 busy, bit 9 error, bit 10 reload in progress, and every other bit zero.
- R3: When reset is released, a reload starts by itself. The busy bit first reads zero in a status read sampled NWORDS·(relax+1)+2 clocks after the release.
- R4: A write to 0x004 with bit 10 set starts a reload, provided the bank is idle and no error is pending. Words are copied one per relax+1 clocks in ascending order. Busy clears so that the first status read showing zero is sampled NWORDS·(relax+1)+2 clocks after the write edge.
- R5: After a reload, every shadow word equals the fuse word at the same index.
- R6: A shadow write to an unlocked word, made while idle and with no error pending, replaces that word's contents.
- R7: A shadow write during a reload sets the error flag and leaves the word unchanged.
- R8: A shadow write to a word whose `wr_lock` bit is high sets the error flag and leaves the word unchanged.
- R9: A shadow read of a word whose `rd_lock` bit is high returns 0xBADABADA and sets the error flag.
- R10: The error flag stays set until a write to 0x008 with bit 9 set. A write to 0x000, or a write to 0x008 without bit 9, leaves it set.
- R11: While the error flag is set, shadow reads return zero, shadow writes are ignored, and reload requests are ignored.
- R12: A reload request made while a reload is already running is ignored. The running reload neither restarts nor stretches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| relax_cycles | input | RELAX_W | Extra clocks between copied words |
| rd_lock | input | NWORDS | Per-word read lock |
| wr_lock | input | NWORDS | Per-word write lock |
| fuse_idx | output | log2(NWORDS) | Fuse word being fetched |
| fuse_word | input | 32 | Fuse array data for `fuse_idx`, combinational |

## Verification
Every read result is due exactly one clock after the sampling edge. The bench drives each strobe at a falling edge and reads `bus_rdata` at the next falling edge, one rising edge later. Write effects are observed only through a later read. Reload length is measured by holding back-to-back status reads against a free-running edge counter. The bench requires the first read showing busy clear to land exactly NWORDS·(relax+1)+2 edges after the request edge or after reset release. The write-during-reload case is issued five edges after the request, after word 0 has been copied and before the last word. This lets the error case be told apart from an ordinary overwrite by the copy.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
    localparam int BUSY_BIT    = 8;
    localparam int ERR_BIT     = 9;
    localparam int RELOAD_BIT  = 10;
    localparam logic [31:0] LOCKED_MARK = 32'hBADA_BADA;
    localparam int WORD_BASE   = 'h400;
    localparam int STRIDE_LG   = 4;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_ARM, SEQ_PACE} seq_state_t;
    typedef enum logic [2:0] {ACC_NONE, ACC_STAT, ACC_SET, ACC_CLR, ACC_WORD} acc_kind_t;
endpackage

// File: rtl/fsb_decode.sv
module fsb_decode
    import fsb_pkg::*;
#(
    parameter int NWORDS = 64,
    parameter int ADDR_W = 13,
    localparam int IW = $clog2(NWORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic [IW-1:0]     idx
);
    localparam int OFF_W = ADDR_W - STRIDE_LG;

    logic [ADDR_W-1:0] rel;
    logic [OFF_W-1:0]  off;

    always_comb begin
        rel  = addr - ADDR_W'(WORD_BASE);
        off  = rel[ADDR_W-1:STRIDE_LG];
        idx  = off[IW-1:0];
        kind = ACC_NONE;
        if (addr == ADDR_W'(0))
            kind = ACC_STAT;
        else if (addr == ADDR_W'(4))
            kind = ACC_SET;
        else if (addr == ADDR_W'(8))
            kind = ACC_CLR;
        else if ((addr >= ADDR_W'(WORD_BASE)) && (rel[STRIDE_LG-1:0] == '0)
                 && (off < OFF_W'(NWORDS)))
            kind = ACC_WORD;
    end
endmodule

// File: rtl/fsb_reload_seq.sv
module fsb_reload_seq
    import fsb_pkg::*;
#(
    parameter int NWORDS  = 64,
    parameter int RELAX_W = 4,
    localparam int IW = $clog2(NWORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RELAX_W-1:0] relax,
    output logic               busy,
    output logic               copy_en,
    output logic [IW-1:0]      copy_idx
);
    localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

    seq_state_t         state_q, state_d;
    logic [RELAX_W-1:0] cnt_q, cnt_d;
    logic [IW-1:0]      idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_ARM;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        unique case (state_q)
            SEQ_IDLE: if (start) state_d = SEQ_ARM;
            SEQ_ARM: begin
                state_d = SEQ_PACE;
                cnt_d   = relax;
                idx_d   = '0;
            end
            SEQ_PACE: begin
                if (cnt_q != '0)
                    cnt_d = cnt_q - RELAX_W'(1);
                else if (idx_q == LAST)
                    state_d = SEQ_IDLE;
                else begin
                    idx_d = idx_q + IW'(1);
                    cnt_d = relax;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != SEQ_IDLE);
        copy_en  = (state_q == SEQ_PACE) && (cnt_q == '0);
        copy_idx = idx_q;
    end

    // R4
    copy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_en && (copy_idx != LAST)) |=> (copy_idx == $past(copy_idx) + IW'(1)))
        else $error("copy index did not step by one");

    // R3
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(copy_en) && ($past(copy_idx) == LAST)))
        else $error("reload ended before last word");
endmodule

// File: rtl/fsb_guard.sv
module fsb_guard
    import fsb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic      rd,
    input  acc_kind_t kind,
    input  logic      clr_bit,
    input  logic      rel_bit,
    input  logic      busy,
    input  logic      rd_locked,
    input  logic      wr_locked,
    output logic      err,
    output logic      word_we,
    output logic      start,
    output logic      rd_mark,
    output logic      rd_pass
);
    logic err_q, err_d;
    logic word_wr, word_rd, clr_req, set_req, viol;

    always_comb begin
        word_wr = wr && (kind == ACC_WORD);
        word_rd = rd && (kind == ACC_WORD);
        clr_req = wr && (kind == ACC_CLR) && clr_bit;
        set_req = wr && (kind == ACC_SET) && rel_bit;
        viol    = !err_q && ((word_wr && (busy || wr_locked)) || (word_rd && rd_locked));
        word_we = word_wr && !err_q && !busy && !wr_locked;
        start   = set_req && !err_q && !busy;
        rd_mark = word_rd && !err_q && rd_locked;
        rd_pass = word_rd && !err_q && !rd_locked;
        if (clr_req)   err_d = 1'b0;
        else if (viol) err_d = 1'b1;
        else           err_d = err_q;
        err = err_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr && (kind == ACC_CLR) && clr_bit)) |=> err_q)
        else $error("error flag dropped without clear");

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past((wr || rd) && (kind == ACC_WORD)))
        else $error("error raised without a shadow access");
endmodule

// File: rtl/fsb_store.sv
module fsb_store #(
    parameter int NWORDS = 64,
    localparam int IW = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [31:0]   wdata,
    input  logic          cp_en,
    input  logic [IW-1:0] cp_idx,
    input  logic [31:0]   cp_data,
    input  logic [IW-1:0] ridx,
    output logic [31:0]   rword
);
    logic [31:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [31:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (cp_en && (cp_idx == IW'(g)))
                q <= cp_data;
            else if (we && (widx == IW'(g)))
                q <= wdata;
        end
        assign words[g] = q;
    end

    assign rword = words[ridx];
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
    import fsb_pkg::*;
#(
    parameter int NWORDS  = 64,
    parameter int ADDR_W  = 13,
    parameter int RELAX_W = 4,
    localparam int IW = $clog2(NWORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [RELAX_W-1:0] relax_cycles,
    input  logic [NWORDS-1:0]  rd_lock,
    input  logic [NWORDS-1:0]  wr_lock,
    output logic [IW-1:0]      fuse_idx,
    input  logic [31:0]        fuse_word
);
    acc_kind_t     kind;
    logic [IW-1:0] idx;
    logic          busy, copy_en, err, word_we, start, rd_mark, rd_pass;
    logic [IW-1:0] copy_idx;
    logic [31:0]   rword, status, rdata_d;

    fsb_decode #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .kind(kind), .idx(idx));

    fsb_reload_seq #(.NWORDS(NWORDS), .RELAX_W(RELAX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .relax(relax_cycles),
        .busy(busy), .copy_en(copy_en), .copy_idx(copy_idx));

    fsb_guard u_guard (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .kind(kind),
        .clr_bit(bus_wdata[ERR_BIT]), .rel_bit(bus_wdata[RELOAD_BIT]),
        .busy(busy), .rd_locked(rd_lock[idx]), .wr_locked(wr_lock[idx]),
        .err(err), .word_we(word_we), .start(start),
        .rd_mark(rd_mark), .rd_pass(rd_pass));

    fsb_store #(.NWORDS(NWORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .we(word_we), .widx(idx), .wdata(bus_wdata),
        .cp_en(copy_en), .cp_idx(copy_idx), .cp_data(fuse_word),
        .ridx(idx), .rword(rword));

    assign fuse_idx = copy_idx;

    always_comb begin
        status             = '0;
        status[BUSY_BIT]   = busy;
        status[ERR_BIT]    = err;
        status[RELOAD_BIT] = busy;
        rdata_d            = '0;
        if (bus_rd) begin
            unique case (kind)
                ACC_STAT, ACC_SET, ACC_CLR: rdata_d = status;
                ACC_WORD: begin
                    if (rd_mark)      rdata_d = LOCKED_MARK;
                    else if (rd_pass) rdata_d = rword;
                end
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rdata_d;
    end

    // R9
    lock_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (kind == ACC_WORD) && rd_lock[idx] && !err) |=> (bus_rdata == LOCKED_MARK))
        else $error("locked read did not return marker");

    // R11
    err_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !busy && bus_wr && (kind == ACC_SET)) |=> !busy)
        else $error("reload accepted while error pending");

    // R11
    err_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && bus_rd && (kind == ACC_WORD)) |=> (bus_rdata == '0))
        else $error("shadow read served while error pending");
endmodule

// File: tb/sim_fuse_shadow_bank.sv
module sim_fuse_shadow_bank;
    localparam int NW = 16;
    localparam int AW = 13;
    localparam int RW = 4;
    localparam int IW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [RW-1:0] relax = RW'(1);
    logic [NW-1:0] rd_lock = '0, wr_lock = '0;
    logic [IW-1:0] fuse_idx;
    logic [31:0]   fuse_word;
    logic [31:0]   fseed = 32'h1357_9BDF;
    logic [31:0]   exp_mem [NW];
    int            cyc = 0;
    int            n_chk = 0, n_err = 0;
    bit            done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] fval(input logic [31:0] s, input int i);
        return s + 32'(i) * 32'h0104_0A11;
    endfunction

    always_comb fuse_word = fval(fseed, int'(fuse_idx));

    fuse_shadow_bank #(.NWORDS(NW), .ADDR_W(AW), .RELAX_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .relax_cycles(relax), .rd_lock(rd_lock), .wr_lock(wr_lock),
        .fuse_idx(fuse_idx), .fuse_word(fuse_word));

    function automatic logic [AW-1:0] waddr(input int i);
        return AW'('h400 + 16 * i);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic poll_done(input int c0, input int r, input string tag);
        logic [31:0] d;
        int lat = -1;
        bit first = 1;
        for (int k = 0; k < 3000; k++) begin
            bus_read(AW'(0), d);
            if (first) begin
                chk({tag, " reload bit mirrors busy"}, 32'(d[10]), 32'(d[8]));
                first = 0;
            end
            if (!d[8]) begin
                lat = cyc - c0;
                break;
            end
        end
        chk({tag, " busy clear latency"}, 32'(lat), 32'(NW * (r + 1) + 2));
    endtask

    task automatic timed_reload(input int r, input bit dup, input string tag);
        int c0;
        relax = RW'(r);
        bus_write(AW'(4), 32'h0000_0400);
        c0 = cyc;
        if (dup) bus_write(AW'(4), 32'h0000_0400);
        poll_done(c0, r, tag);
        for (int i = 0; i < NW; i++) exp_mem[i] = fval(fseed, i);
    endtask

    task automatic sweep_words(input string tag);
        logic [31:0] d;
        for (int i = 0; i < NW; i++) begin
            bus_read(waddr(i), d);
            chk(tag, d, exp_mem[i]);
        end
    endtask

    initial begin
        logic [31:0] d;
        int c0;
        @(negedge clk);
        chk("R1 reset rdata", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        c0 = cyc;
        poll_done(c0, 1, "R3 reset reload");
        for (int i = 0; i < NW; i++) exp_mem[i] = fval(fseed, i);
        sweep_words("R5 reset contents");
        bus_read(AW'(0), d);  chk("R2 idle status", d, 32'h0);
        bus_read(AW'(8), d);  chk("R2 status alias", d, 32'h0);

        bus_read(AW'('h40C), d);              chk("R1 unaligned read", d, 32'h0);
        bus_read(AW'('h400 + 16 * NW), d);    chk("R1 out of range read", d, 32'h0);
        bus_read(AW'('h00C), d);              chk("R1 unmapped read", d, 32'h0);
        bus_write(AW'('h404), 32'hFFFF_FFFF);
        bus_write(AW'('h400 + 16 * NW), 32'hFFFF_FFFF);
        sweep_words("R1 ignored stray writes");

        for (int i = 0; i < NW; i++) begin
            exp_mem[i] = 32'hA500_0000 | (32'(i) * 32'h0001_0203);
            bus_write(waddr(i), exp_mem[i]);
        end
        sweep_words("R6 write back");

        fseed = 32'h2468_ACE0;
        timed_reload(0, 0, "R4 relax0");
        sweep_words("R5 relax0 contents");
        fseed = 32'hCAFE_0001;
        timed_reload(2, 0, "R4 relax2");
        sweep_words("R5 relax2 contents");
        fseed = 32'h0F0F_7777;
        timed_reload(3, 1, "R12 repeat request");
        sweep_words("R5 relax3 contents");

        // R7: shadow write during reload
        fseed = 32'h5555_1234;
        relax = RW'(0);
        bus_write(AW'(4), 32'h0000_0400);
        c0 = cyc;
        for (int k = 0; k < 4; k++) bus_read(AW'(0), d);
        bus_write(waddr(0), 32'h1111_1111);
        for (int k = 0; k < 100; k++) begin
            bus_read(AW'(0), d);
            if (!d[8]) break;
        end
        for (int i = 0; i < NW; i++) exp_mem[i] = fval(fseed, i);
        chk("R7 error after busy write", d, 32'h0000_0200);
        bus_read(waddr(1), d);                 chk("R11 read blocked", d, 32'h0);
        bus_write(waddr(3), 32'h3333_3333);
        bus_write(AW'(4), 32'h0000_0400);
        bus_read(AW'(0), d);                   chk("R11 reload refused", d, 32'h0000_0200);
        bus_write(AW'(0), 32'h0000_0200);
        bus_read(AW'(0), d);                   chk("R10 base write keeps error", d, 32'h0000_0200);
        bus_write(AW'(8), 32'h0000_0100);
        bus_read(AW'(0), d);                   chk("R10 wrong bit keeps error", d, 32'h0000_0200);
        bus_write(AW'(8), 32'h0000_0200);
        bus_read(AW'(0), d);                   chk("R10 clear", d, 32'h0);
        bus_read(waddr(0), d);                 chk("R7 word unchanged", d, exp_mem[0]);
        bus_read(waddr(3), d);                 chk("R11 write ignored", d, exp_mem[3]);

        // R8: write lock
        wr_lock[7] = 1'b1;
        bus_write(waddr(7), 32'hDEAD_0007);
        bus_read(AW'(0), d);                   chk("R8 error on locked write", d, 32'h0000_0200);
        bus_write(AW'(8), 32'h0000_0200);
        bus_read(waddr(7), d);                 chk("R8 locked word unchanged", d, exp_mem[7]);
        exp_mem[8] = 32'h0808_0808;
        bus_write(waddr(8), exp_mem[8]);
        bus_read(waddr(8), d);                 chk("R6 neighbour of lock", d, exp_mem[8]);
        wr_lock = '0;

        // R9: read lock
        rd_lock[2] = 1'b1;
        bus_read(waddr(2), d);                 chk("R9 marker", d, 32'hBADA_BADA);
        bus_read(AW'(0), d);                   chk("R9 error set", d, 32'h0000_0200);
        bus_write(AW'(8), 32'h0000_0200);
        bus_read(waddr(3), d);                 chk("R9 other word readable", d, exp_mem[3]);
        rd_lock = '0;
        bus_read(waddr(2), d);                 chk("R9 unlocked again", d, exp_mem[2]);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule